// File: doc/BRIEF.md
# SHA-256 Block Compression Core

This core takes one already padded 512-bit message block and runs the SHA-256 compression function on it, one round per clock over 64 rounds, then folds the result into a 256-bit running digest. A block is offered with a valid/ready handshake, together with a flag that marks the first block of a message. At the end of each block the core raises a one-cycle completion pulse, and the digest port then holds the updated hash value. Longer messages are hashed by offering their blocks in order with the flag low after the first one.

Inside, only the two working words that need arithmetic (the first and fifth) are recomputed each round. The other six are plain copies of their neighbours from the previous round. The 64 round constants stream from a ROM whose address advances once per round and wraps from the top back to zero, so every block starts on the first constant. The schedule words come from a sixteen-word window that shifts in place and grows by modular addition. A bank of eight 32-bit adders does two jobs. When a first block is accepted, it adds the initial vector to a cleared digest. After the last round, it adds the working words to the digest.

Top module: `sha256_core`

## Requirements
- R1: While reset is held and right after it is released, `blk_ready` is 1, `done` is 0 and `digest` is all zero.
- R2: A block is accepted on a rising edge where `blk_valid` and `blk_ready` are both 1. `blk_ready` is 0 from the edge after acceptance until the block completes, and `blk_valid` has no effect while `blk_ready` is 0.
- R3: `done` rises on the 65th rising edge after the accepting edge and is high for exactly one cycle. `blk_ready` is 1 again from that same edge.
- R4: When a block is accepted with `blk_first` = 1, `digest` becomes the initial vector at the accepting edge (a cleared digest plus the vector). When `done` rises, `digest` equals the SHA-256 compression of that block from the initial vector (for "abc": ba7816bf...f20015ad).
- R5: When a block is accepted with `blk_first` = 0, the compression starts from the current `digest`, and the result is that digest plus the working words.
- R6: Word order is big-endian. `blk_data[511:480]` is schedule word 0 and `blk_data[31:0]` is word 15. `digest[255:224]` is hash word 0 and `digest[31:0]` is hash word 7.
- R7: The constant ROM address advances by one per round and wraps from 63 to 0, so it equals the round index during every round and each block uses constants 0 to 63 in order.
- R8: Each round computes new values only for words A and E. B, C, D take the previous A, B, C, and F, G, H take the previous E, F, G.
- R9: Rounds 0 to 15 use the block's own words. Later rounds use sigma1(W[t-2]) + W[t-7] + sigma0(W[t-15]) + W[t-16] mod 2^32.
- R10: `digest` changes only at an edge that raises `done` or that accepts a first block, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blk_valid | input | 1 | A block is offered on `blk_data` |
| blk_ready | output | 1 | Core is idle and will take a block |
| blk_first | input | 1 | Offered block is the first of a message |
| blk_data | input | 512 | Padded message block, word 0 in the top bits |
| digest | output | 256 | Running hash value, word 0 in the top bits |
| done | output | 1 | One-cycle pulse when a block has been folded into `digest` |

## Verification
Almost any internal fault shows up only once, in the digest that appears with the completion pulse 65 edges after acceptance. This includes a wrong constant, a misrouted copy word or a schedule tap off by one. The bench therefore compares whole digests against an arithmetic model and known answers over many chained blocks. A fault in the initial load can be seen earlier: the digest port must read the initial vector during the whole of a first block. Timing faults (a late pulse, or a block taken while busy) show at the handshake within the same block.

// File: rtl/sha2c_pkg.sv
package sha2c_pkg;
  localparam int WORD_W   = 32;
  localparam int N_ROUNDS = 64;
  localparam int WIN_LEN  = 16;
  localparam int N_HWORDS = 8;
  localparam int BLK_W    = WIN_LEN * WORD_W;
  localparam int DIG_W    = N_HWORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FOLD = 2'd2} core_st_e;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t f_choose(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t f_major(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic word_t start_word(input logic [2:0] i);
    case (i)
      3'd0: return 32'h6a09e667;
      3'd1: return 32'hbb67ae85;
      3'd2: return 32'h3c6ef372;
      3'd3: return 32'ha54ff53a;
      3'd4: return 32'h510e527f;
      3'd5: return 32'h9b05688c;
      3'd6: return 32'h1f83d9ab;
      default: return 32'h5be0cd19;
    endcase
  endfunction

  function automatic word_t round_const(input logic [5:0] i);
    case (i)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction
endpackage

// File: rtl/sha2c_kconst.sv
module sha2c_kconst
  import sha2c_pkg::*;
#(
  parameter int ROUNDS = N_ROUNDS,
  localparam int AW = $clog2(ROUNDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] addr,
  output word_t         k_out
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (step) begin
      if (addr_q == AW'(ROUNDS - 1)) addr_d = '0;
      else                           addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr  = addr_q;
  assign k_out = round_const(6'(addr_q));

  // R7: top address wraps to zero on the next round
  p_addr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && addr_q == AW'(ROUNDS - 1)) |=> (addr_q == '0));
endmodule

// File: rtl/sha2c_msg_window.sv
module sha2c_msg_window
  import sha2c_pkg::*;
#(
  parameter int WIN = WIN_LEN,
  localparam int BW = WIN * WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [BW-1:0] blk,
  output word_t         w_cur,
  output word_t         w_next
);
  word_t win_q [WIN];
  word_t win_d [WIN];
  word_t grown;

  assign grown = sml_sig1(win_q[WIN-2]) + win_q[WIN-7] + sml_sig0(win_q[1]) + win_q[0];

  always_comb begin
    for (int i = 0; i < WIN; i++) win_d[i] = win_q[i];
    if (load) begin
      for (int i = 0; i < WIN; i++) win_d[i] = blk[(WIN-1-i)*WORD_W +: WORD_W];
    end else if (step) begin
      for (int i = 0; i < WIN-1; i++) win_d[i] = win_q[i+1];
      win_d[WIN-1] = grown;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win_q[i] <= '0;
    end else begin
      for (int i = 0; i < WIN; i++) win_q[i] <= win_d[i];
    end
  end

  assign w_cur  = win_q[0];
  assign w_next = win_q[1];

  // R9: window shifts one word per round
  p_window_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (w_cur == $past(w_next)));
endmodule

// File: rtl/sha2c_round_regs.sv
module sha2c_round_regs
  import sha2c_pkg::*;
#(
  parameter int NW = N_HWORDS,
  localparam int SW = NW * WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] init,
  input  logic          step,
  input  word_t         k_in,
  input  word_t         w_in,
  output logic [SW-1:0] work
);
  word_t st_q [NW];
  word_t st_d [NW];
  word_t t1, t2;

  assign t1 = st_q[7] + big_sig1(st_q[4]) + f_choose(st_q[4], st_q[5], st_q[6]) + k_in + w_in;
  assign t2 = big_sig0(st_q[0]) + f_major(st_q[0], st_q[1], st_q[2]);

  always_comb begin
    for (int i = 0; i < NW; i++) st_d[i] = st_q[i];
    if (load) begin
      for (int i = 0; i < NW; i++) st_d[i] = init[SW-1-i*WORD_W -: WORD_W];
    end else if (step) begin
      st_d[0] = t1 + t2;
      st_d[1] = st_q[0];
      st_d[2] = st_q[1];
      st_d[3] = st_q[2];
      st_d[4] = st_q[3] + t1;
      st_d[5] = st_q[4];
      st_d[6] = st_q[5];
      st_d[7] = st_q[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) st_q[i] <= '0;
    end else begin
      for (int i = 0; i < NW; i++) st_q[i] <= st_d[i];
    end
  end

  generate
    for (genvar g = 0; g < NW; g++) begin : g_pack
      assign work[SW-1-g*WORD_W -: WORD_W] = st_q[g];
    end
  endgenerate

  // R8: B,C,D and F,G,H are copies of the previous A,B,C and E,F,G
  p_shift_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (work[223:128] == $past(work[255:160]) &&
                         work[95:0]    == $past(work[127:32])));
endmodule

// File: rtl/sha256_core.sv
module sha256_core
  import sha2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  output logic             blk_ready,
  input  logic             blk_first,
  input  logic [BLK_W-1:0] blk_data,
  output logic [DIG_W-1:0] digest,
  output logic             done
);
  localparam int CW = $clog2(N_ROUNDS);

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  core_st_e       st_q, st_d;
  logic [CW-1:0]  rnd_q, rnd_d;
  logic           done_q, done_d;
  logic           accept, running, folding, upd_en;
  logic [CW-1:0]  k_addr;
  word_t          k_word, w_word, w_peek;
  logic [DIG_W-1:0] work, init_vec, iv_vec, dig_q, dig_d, fold_sum;

  assign blk_ready = (st_q == ST_IDLE);
  assign accept    = blk_valid && blk_ready;
  assign running   = (st_q == ST_RUN);
  assign folding   = (st_q == ST_FOLD);

  always_comb begin
    st_d   = st_q;
    rnd_d  = rnd_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d  = ST_RUN;
        rnd_d = '0;
      end
      ST_RUN: begin
        rnd_d = rnd_q + CW'(1);
        if (rnd_q == CW'(N_ROUNDS - 1)) st_d = ST_FOLD;
      end
      ST_FOLD: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

  sha2c_kconst #(.ROUNDS(N_ROUNDS)) u_kconst (
    .clk(clk), .rst_n(rst_i_n), .step(running), .addr(k_addr), .k_out(k_word)
  );

  sha2c_msg_window #(.WIN(WIN_LEN)) u_window (
    .clk(clk), .rst_n(rst_i_n), .load(accept), .step(running),
    .blk(blk_data), .w_cur(w_word), .w_next(w_peek)
  );

  sha2c_round_regs #(.NW(N_HWORDS)) u_rounds (
    .clk(clk), .rst_n(rst_i_n), .load(accept), .init(init_vec), .step(running),
    .k_in(k_word), .w_in(w_word), .work(work)
  );

  // Eight adders: initial vector onto a cleared digest, or working words onto the digest
  generate
    for (genvar g = 0; g < N_HWORDS; g++) begin : g_fold
      word_t opa, opb;
      assign iv_vec[DIG_W-1-g*WORD_W -: WORD_W] = start_word(3'(g));
      assign opa = folding ? work[DIG_W-1-g*WORD_W -: WORD_W] : start_word(3'(g));
      assign opb = folding ? dig_q[DIG_W-1-g*WORD_W -: WORD_W] : '0;
      assign fold_sum[DIG_W-1-g*WORD_W -: WORD_W] = opa + opb;
    end
  endgenerate

  assign init_vec = blk_first ? iv_vec : dig_q;
  assign upd_en   = folding || (accept && blk_first);

  always_comb begin
    dig_d = dig_q;
    if (upd_en) dig_d = fold_sum;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) dig_q <= '0;
    else          dig_q <= dig_d;
  end

  assign digest = dig_q;
  assign done   = done_q;

  // R3: completion is a single-cycle pulse with the core idle again
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  p_done_ready_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> blk_ready);
  // R2: the core is busy right after it takes a block
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept |=> !blk_ready);
  // R7: constant address tracks the round index
  p_rom_align_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    running |-> (k_addr == rnd_q));
  // R10: digest moves only on completion or first-block acceptance
  p_digest_hold_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(digest) |-> (done || $past(accept && blk_first)));
endmodule

// File: tb/tb_sha256_core.sv
module tb_sha256_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         blk_valid, blk_first, blk_ready, done;
  logic [511:0] blk_data;
  logic [255:0] digest;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [31:0] kb [64];
  logic [31:0] ivb [8];
  logic [63:0] rng = 64'h0123_4567_89ab_cdef;

  sha256_core dut (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_first(blk_first), .blk_data(blk_data), .digest(digest), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_compress(input logic [255:0] hin, input logic [511:0] m);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2, s0, s1;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = m[511-32*t -: 32];
    for (int t = 16; t < 64; t++) begin
      s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
      s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
      w[t] = s1 + w[t-7] + s0 + w[t-16];
    end
    for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25)) +
           ((v[4] & v[5]) ^ (~v[4] & v[6])) + kb[t] + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22)) +
           ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = hin[255-32*i -: 32] + v[i];
    return r;
  endfunction

  function automatic logic [255:0] iv_vec();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = ivb[i];
    return r;
  endfunction

  task automatic build_consts();
    int pr [64];
    int n = 2, c = 0;
    logic [127:0] x, cand, acc;
    while (c < 64) begin
      bit isp = 1;
      for (int d = 2; d * d <= n; d++) if (n % d == 0) isp = 0;
      if (isp) begin pr[c] = n; c++; end
      n++;
    end
    for (int i = 0; i < 64; i++) begin
      x = 128'(pr[i]) << 96; acc = '0;
      for (int b = 39; b >= 0; b--) begin
        cand = acc | (128'(1) << b);
        if (cand * cand * cand <= x) acc = cand;
      end
      kb[i] = acc[31:0];
    end
    for (int i = 0; i < 8; i++) begin
      x = 128'(pr[i]) << 64; acc = '0;
      for (int b = 39; b >= 0; b--) begin
        cand = acc | (128'(1) << b);
        if (cand * cand <= x) acc = cand;
      end
      ivb[i] = acc[31:0];
    end
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] y = s;
    y ^= y << 13; y ^= y >> 7; y ^= y << 17;
    return y;
  endfunction

  // Offers one block; checks handshake, latency, pulse width, and IV load
  task automatic run_block(input logic [511:0] data, input bit first, input bit glitch,
                           output logic [255:0] got);
    int cnt = 0;
    @(negedge clk);
    while (!blk_ready) @(negedge clk);
    blk_valid = 1'b1; blk_first = first; blk_data = data;
    @(negedge clk);
    blk_valid = 1'b0; blk_first = 1'b0;
    chk(blk_ready == 1'b0, "R2 ready low after accept", 256'(blk_ready), 256'(0));
    while (!done && cnt < 200) begin
      if (glitch && cnt == 5) begin
        blk_valid = 1'b1; blk_first = 1'b1; blk_data = ~data;
      end
      if (glitch && cnt == 9) begin
        blk_valid = 1'b0; blk_first = 1'b0;
      end
      if (first && cnt == 20)
        chk(digest == iv_vec(), "R4 digest holds initial vector during first block", digest, iv_vec());
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 65, "R3 done latency", 256'(cnt), 256'(65));
    chk(blk_ready == 1'b1, "R3 ready with done", 256'(blk_ready), 256'(1));
    got = digest;
    @(negedge clk);
    chk(done == 1'b0, "R3 done single cycle", 256'(done), 256'(0));
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !finished) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [255:0] got, exp, prev;
    logic [447:0] msg2 = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
    logic [511:0] abc_blk = {24'h616263, 8'h80, 416'h0, 64'd24};
    logic [511:0] b1 = {msg2, 8'h80, 56'h0};
    logic [511:0] b2 = {448'h0, 64'd448};
    logic [511:0] rb;
    build_consts();
    blk_valid = 0; blk_first = 0; blk_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(blk_ready == 1 && done == 0 && digest == '0, "R1 reset state",
        {digest[253:0], blk_ready, done}, 256'(2));
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(blk_ready == 1 && done == 0 && digest == '0, "R1 after release",
        {digest[253:0], blk_ready, done}, 256'(2));

    // R4 R6: single block known answer
    run_block(abc_blk, 1, 0, got);
    exp = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    chk(got == exp, "R4 R6 abc digest", got, exp);

    // R5: two-block chaining, with valid toggled while busy (R2)
    run_block(b1, 1, 1, got);
    exp = ref_compress(iv_vec(), b1);
    chk(got == exp, "R4 first of two blocks", got, exp);
    run_block(b2, 0, 1, got);
    exp = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
    chk(got == exp, "R5 R2 two-block digest", got, exp);

    // R10: idle digest holds without stimulus, and with valid low
    prev = digest;
    repeat (12) @(negedge clk);
    chk(digest == prev, "R10 digest holds while idle", digest, prev);

    // R4 R7: restart with first flag after chaining
    run_block(abc_blk, 1, 0, got);
    exp = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    chk(got == exp, "R4 R7 restart abc", got, exp);

    // R8 R9: sweep of pseudo-random chained messages against model
    for (int m = 0; m < 10; m++) begin
      prev = iv_vec();
      for (int b = 0; b < 3; b++) begin
        for (int q = 0; q < 8; q++) begin
          rng = nxt(rng);
          rb[511-64*q -: 64] = rng;
        end
        if (m == 0 && b == 0) rb = '0;
        if (m == 1 && b == 0) rb = '1;
        run_block(rb, b == 0, m % 2 == 1, got);
        exp = ref_compress(prev, rb);
        chk(got == exp, "R8 R9 sweep digest", got, exp);
        prev = exp;
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule